// File: doc/BRIEF.md
# Ping-pong one-shot DMA channel bank

This block moves words from seven peripherals into memory. Every channel carries two descriptor sets, each made of a start address, a byte count and a command word. At any moment one set drives the transfer while software prepares the other. When the driving set runs out of bytes it raises its done flag and disarms itself. If the partner set is already armed, the channel then switches over to it, so a stream can continue without a gap in the descriptor chain.

Each peripheral signals that a data word is ready through a request line. The bank answers with a one-cycle acknowledge when it takes the word. Requests from all channels compete for a single word-wide memory write port, and the lowest channel index always wins. Software reaches the descriptors and a small per-channel control word through a simple synchronous register port. A read returns its data one cycle after the read strobe.

The channels are ordered by index 0 to 6: disk interface, network receive, network transmit, floppy, serial A receive, serial B receive, serial A transmit.

Top module: `pp_dma_bank`

## Requirements
- R1: After reset every set is unarmed with its done flag clear, every channel has set 0 active and is disabled, and there is no memory write and no acknowledge.
- R2: The control word of channel c is at byte offset 0xC00 + 0x10*c, with bit 0 = active set (read-only) and bit 1 = enable. Set s of channel c starts at 0x1000 + 0x20*c + 0x10*s, with the address at +0, the length (16 bits, bytes) at +4 and the command at +8. `reg_rdata` holds the read value one cycle after `reg_rd`.
- R3: A command write sets the armed bit to write-data bit 0 and clears the set's done flag. A command read returns armed in bit 0 and done in bit 1.
- R4: An enabled channel whose active set is armed with a nonzero length, and whose `periph_req` is high, issues a memory write of its `periph_data` lane to the set's current address. The address then advances by 4 and the length drops by up to 4. `periph_ack` pulses for one cycle together with the issued write, and the channel is not granted again while its acknowledge is high.
- R5: Byte enables are 4'b1111 while 4 or more bytes remain. With 1, 2 or 3 bytes left they are 4'b0001, 4'b0011 or 4'b0111 (lane 0 = low byte).
- R6: When the length of the active armed set reaches zero, its done flag (`set_done` bit 2*c+s) is set and the set is disarmed. A set armed with length 0 completes this way without any memory write.
- R7: A channel whose active set is unarmed switches to its other set when that set is armed. After a completion it therefore moves to the partner only if the partner is armed, and otherwise stays where it is.
- R8: Writes to any register of the active, armed set are ignored. Writes to the other set take effect at once.
- R9: When several channels are eligible in the same cycle, the lowest index is granted.
- R10: While `mem_wr_valid` is high and `mem_wr_ready` is low, the address, data and byte enables hold steady and no channel is granted.
- R11: A disabled channel issues no writes, does not switch sets and does not complete zero-length sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| periph_req | input | NCH | Per-channel data-ready request |
| periph_data | input | 32*NCH | Per-channel data word, channel c in bits 32c+31:32c |
| periph_ack | output | NCH | Per-channel one-cycle acknowledge |
| mem_wr_valid | output | 1 | Memory write request valid |
| mem_wr_ready | input | 1 | Memory accepts the request |
| mem_wr_addr | output | AW | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_be | output | 4 | Memory write byte enables |
| set_done | output | 2*NCH | Done flag per set, bit 2c+s |

## Verification
The bench drives a two-set chain in which the first set ends on a 2-byte tail. A design that mishandles the tail would write a full word or drop the last bytes, and one that fails to switch sets would stall before the second buffer. It rewrites the active set's address in the middle of a transfer. A bank without write protection would then leave a corrupted address behind after completion. It also arms a zero-length set, which a naive design either never finishes or turns into a spurious write. It stalls the memory port while two channels compete, to expose arbiters that favour the wrong index or that grant new work into a held request. Finally it arms a set on a disabled channel, which would reveal a channel that switches sets or transfers while switched off.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  localparam int REG_AW     = 13;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_LEN  = 2'd1,
    FLD_CMD  = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  // Byte lanes still covered by the remaining count (lane 0 = low byte).
  function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [31:0] rem);
    if (rem >= 32'(WORD_BYTES)) return '1;
    case (rem[1:0])
      2'd1:    return 4'b0001;
      2'd2:    return 4'b0011;
      2'd3:    return 4'b0111;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/pp_dma_prio.sv
module pp_dma_prio #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         free,
  output logic [N-1:0] gnt
);

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (free && req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  p_single_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  for (genvar gi = 1; gi < N; gi++) begin : g_low_wins
    p_lowest_wins_r9: assert property (@(posedge clk) disable iff (rst)
      gnt[gi] |-> !(|req[gi-1:0]));
  end

endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  sel_ctrl,
  input  logic                  sel_set,
  input  fld_e                  sel_fld,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  periph_req,
  input  logic                  grant,
  output logic                  want,
  output logic [AW-1:0]         cur_addr,
  output logic [WORD_BYTES-1:0] cur_be,
  output logic                  ack,
  output logic [1:0]            done
);

  logic [AW-1:0] addr_q [2];
  logic [LW-1:0] len_q  [2];
  logic [1:0]    armed_q;
  logic [1:0]    done_q;
  logic          act_q;
  logic          en_q;
  logic          ack_q;

  logic [LW-1:0] cur_len;
  logic [LW-1:0] step;
  logic          act_armed;
  logic          wr_blocked;

  assign cur_len    = len_q[act_q];
  assign act_armed  = armed_q[act_q];
  assign step       = (cur_len >= LW'(WORD_BYTES)) ? LW'(WORD_BYTES) : cur_len;
  assign wr_blocked = (sel_set == act_q) && act_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q[0] <= '0;
      addr_q[1] <= '0;
      len_q[0]  <= '0;
      len_q[1]  <= '0;
      armed_q   <= '0;
      done_q    <= '0;
      act_q     <= 1'b0;
      en_q      <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_q <= grant;
      // software side
      if (wr_en) begin
        if (sel_ctrl) begin
          en_q <= wdata[1];
        end else if (!wr_blocked) begin
          case (sel_fld)
            FLD_ADDR: addr_q[sel_set] <= wdata[AW-1:0];
            FLD_LEN:  len_q[sel_set]  <= wdata[LW-1:0];
            FLD_CMD: begin
              armed_q[sel_set] <= wdata[0];
              done_q[sel_set]  <= 1'b0;
            end
            default: ;
          endcase
        end
      end
      // transfer sequencing
      if (en_q) begin
        if (grant) begin
          addr_q[act_q] <= cur_addr + AW'(WORD_BYTES);
          len_q[act_q]  <= cur_len - step;
          if (cur_len <= LW'(WORD_BYTES)) begin
            done_q[act_q]  <= 1'b1;
            armed_q[act_q] <= 1'b0;
          end
        end else if (act_armed && cur_len == '0) begin
          done_q[act_q]  <= 1'b1;
          armed_q[act_q] <= 1'b0;
        end else if (!act_armed && armed_q[!act_q]) begin
          act_q <= !act_q;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_ctrl) begin
      rd_data[1:0] = {en_q, act_q};
    end else begin
      case (sel_fld)
        FLD_ADDR: rd_data = DATA_W'(addr_q[sel_set]);
        FLD_LEN:  rd_data = DATA_W'(len_q[sel_set]);
        FLD_CMD:  rd_data[1:0] = {done_q[sel_set], armed_q[sel_set]};
        default:  rd_data = '0;
      endcase
    end
  end

  assign want     = en_q && act_armed && (cur_len != '0) && periph_req && !ack_q;
  assign cur_addr = addr_q[act_q];
  assign cur_be   = lane_mask(32'(cur_len));
  assign ack      = ack_q;
  assign done     = done_q;

  p_switch_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> $past(!act_armed));

  p_frozen_when_off_r11: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> $past(en_q));

  p_grant_needs_bytes_r6: assert property (@(posedge clk) disable iff (rst)
    grant |-> (en_q && cur_len != '0));

  for (genvar gs = 0; gs < 2; gs++) begin : g_set_chk
    p_done_disarms_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(done_q[gs]) |-> !armed_q[gs]);
  end

endmodule

// File: rtl/pp_dma_bank.sv
module pp_dma_bank
  import pp_dma_pkg::*;
#(
  parameter int NCH = 7,
  parameter int AW  = 32,
  parameter int LW  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NCH-1:0]        periph_req,
  input  logic [NCH*DATA_W-1:0] periph_data,
  output logic [NCH-1:0]        periph_ack,
  output logic                  mem_wr_valid,
  input  logic                  mem_wr_ready,
  output logic [AW-1:0]         mem_wr_addr,
  output logic [DATA_W-1:0]     mem_wr_data,
  output logic [WORD_BYTES-1:0] mem_wr_be,
  output logic [2*NCH-1:0]      set_done
);

  localparam int CHW = 3;

  // address decode
  logic           is_ctrl, is_set, hit_ok, sel_set;
  logic [CHW-1:0] hit_ch;
  fld_e           sel_fld;

  assign is_ctrl = (reg_addr[12:7] == 6'b011000) && (reg_addr[3:0] == 4'h0);
  assign is_set  = reg_addr[12] && (reg_addr[11:8] == 4'h0) && (reg_addr[1:0] == 2'b00);
  assign hit_ch  = is_ctrl ? reg_addr[6:4] : reg_addr[7:5];
  assign hit_ok  = (is_ctrl || is_set) && (int'(hit_ch) < NCH);
  assign sel_set = reg_addr[4];
  assign sel_fld = is_set ? fld_e'(reg_addr[3:2]) : FLD_NONE;

  logic [DATA_W-1:0]     chan_rd   [NCH];
  logic [AW-1:0]         chan_addr [NCH];
  logic [WORD_BYTES-1:0] chan_be   [NCH];
  logic [NCH-1:0]        want, gnt;
  logic                  port_free;

  for (genvar gc = 0; gc < NCH; gc++) begin : g_chan
    pp_dma_chan #(.AW(AW), .LW(LW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (reg_wr && hit_ok && (int'(hit_ch) == gc)),
      .sel_ctrl   (is_ctrl),
      .sel_set    (sel_set),
      .sel_fld    (sel_fld),
      .wdata      (reg_wdata),
      .rd_data    (chan_rd[gc]),
      .periph_req (periph_req[gc]),
      .grant      (gnt[gc]),
      .want       (want[gc]),
      .cur_addr   (chan_addr[gc]),
      .cur_be     (chan_be[gc]),
      .ack        (periph_ack[gc]),
      .done       (set_done[2*gc +: 2])
    );
  end

  assign port_free = !mem_wr_valid || mem_wr_ready;

  pp_dma_prio #(.N(NCH)) u_prio (
    .clk  (clk),
    .rst  (rst),
    .req  (want),
    .free (port_free),
    .gnt  (gnt)
  );

  logic [DATA_W-1:0]     rd_mux, win_data;
  logic [AW-1:0]         win_addr;
  logic [WORD_BYTES-1:0] win_be;

  always_comb begin
    rd_mux   = '0;
    win_data = '0;
    win_addr = '0;
    win_be   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(hit_ch) == i) rd_mux = chan_rd[i];
      if (gnt[i]) begin
        win_data = periph_data[i*DATA_W +: DATA_W];
        win_addr = chan_addr[i];
        win_be   = chan_be[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_wr_be    <= '0;
    end else begin
      reg_rdata <= (reg_rd && hit_ok) ? rd_mux : '0;
      if (port_free) begin
        mem_wr_valid <= |gnt;
        if (|gnt) begin
          mem_wr_addr <= win_addr;
          mem_wr_data <= win_data;
          mem_wr_be   <= win_be;
        end
      end
    end
  end

  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)
      && $stable(mem_wr_data) && $stable(mem_wr_be)));

  p_no_grant_on_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |-> (gnt == '0));

  p_write_has_lanes_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_be != '0));

endmodule

// File: tb/pp_dma_bank_tb.sv
`timescale 1ns/1ps
module pp_dma_bank_tb;

  localparam int NCH = 7;
  localparam int CLK_PERIOD = 20;
  localparam int NTV = 8;

  // register table: offset, write data, expected readback
  localparam logic [12:0] TV_ADDR [NTV] = '{13'h1000, 13'h10D4, 13'h1044, 13'h10B8,
                                            13'h10B8, 13'h0C20, 13'h0C20, 13'h1070};
  localparam logic [31:0] TV_WDAT [NTV] = '{32'h0000_1230, 32'h23, 32'h0001_0007, 32'h1,
                                            32'h0, 32'h3, 32'h0, 32'hFFFF_FFFC};
  localparam logic [31:0] TV_EXP  [NTV] = '{32'h0000_1230, 32'h23, 32'h0007, 32'h1,
                                            32'h0, 32'h2, 32'h0, 32'hFFFF_FFFC};

  logic              clk = 0;
  logic              rst = 1;
  logic              wr = 0, rd = 0;
  logic [12:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH-1:0]    preq = '0;
  logic [NCH*32-1:0] pdata;
  logic [NCH-1:0]    pack;
  logic              mem_wr_valid;
  logic              rdy = 1;
  logic [31:0]       mem_wr_addr, mem_wr_data;
  logic [3:0]        mem_wr_be;
  logic [2*NCH-1:0]  set_done;

  int n_chk = 0, n_fail = 0;
  int log_n = 0;
  logic [31:0] log_addr [32];
  logic [31:0] log_data [32];
  logic [3:0]  log_be   [32];
  int acks [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pword(input int ch);
    return {8'hD0, 8'(ch), 16'hBEEF};
  endfunction

  always_comb
    for (int c = 0; c < NCH; c++) pdata[c*32 +: 32] = pword(c);

  pp_dma_bank #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .periph_req(preq), .periph_data(pdata),
    .periph_ack(pack), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(rdy),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .set_done(set_done)
  );

  // memory and acknowledge monitor, away from the active edge
  initial for (int c = 0; c < NCH; c++) acks[c] = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr_valid && rdy && log_n < 32) begin
        log_addr[log_n] = mem_wr_addr;
        log_data[log_n] = mem_wr_data;
        log_be[log_n]   = mem_wr_be;
        log_n++;
      end
      for (int c = 0; c < NCH; c++) if (pack[c]) acks[c]++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [12:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic reg_read(input logic [12:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    rd = 1; addr = a;
    @(posedge clk); #1;
    rd = 0;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base_n;
    wait_cyc(4);
    rst = 0;
    wait_cyc(1);

    // R1 reset state
    chk("R1 valid", 32'(mem_wr_valid), 0);
    chk("R1 done", 32'(set_done), 0);
    chk("R1 ack", 32'(pack), 0);
    reg_read(13'h0C00, v); chk("R1 ctrl ch0", v, 0);
    reg_read(13'h1078, v); chk("R1 cmd ch3 set1", v, 0);

    // R2 register map via table
    for (int i = 0; i < NTV; i++) begin
      reg_write(TV_ADDR[i], TV_WDAT[i]);
      reg_read(TV_ADDR[i], v);
      chk("R2 table", v, TV_EXP[i]);
    end

    // R4 R5 R6 R7 R8: ch1 chain of two sets
    reg_write(13'h1020, 32'h2000);
    reg_write(13'h1024, 32'd10);
    reg_write(13'h1030, 32'h3000);
    reg_write(13'h1034, 32'd4);
    reg_write(13'h1028, 32'h1);
    reg_write(13'h1038, 32'h1);
    reg_write(13'h0C10, 32'h2);
    base_n = log_n;
    preq[1] = 1;
    reg_write(13'h1020, 32'h7777);   // active armed set: must be ignored
    wait_cyc(30);
    preq[1] = 0;
    chk("R4 write count", 32'(log_n - base_n), 4);
    chk("R4 addr0", log_addr[base_n], 32'h2000);
    chk("R4 data0", log_data[base_n], pword(1));
    chk("R4 addr1", log_addr[base_n+1], 32'h2004);
    chk("R5 be full", 32'(log_be[base_n+1]), 32'hF);
    chk("R5 be tail", 32'(log_be[base_n+2]), 32'h3);
    chk("R7 switched addr", log_addr[base_n+3], 32'h3000);
    chk("R4 acks", 32'(acks[1]), 4);
    chk("R6 done flags", 32'(set_done[3:2]), 32'h3);
    reg_read(13'h0C10, v); chk("R7 active set1", v, 32'h3);
    reg_read(13'h1020, v); chk("R8 protected addr", v, 32'h200C);
    reg_read(13'h1028, v); chk("R6 cmd readback", v, 32'h2);
    reg_read(13'h1024, v); chk("R6 length zero", v, 0);

    // R6 R3 zero-length set on ch3
    base_n = log_n;
    preq[3] = 1;
    reg_write(13'h0C30, 32'h2);
    reg_write(13'h1068, 32'h1);
    wait_cyc(5);
    chk("R6 zero len no write", 32'(log_n - base_n), 0);
    chk("R6 zero len done", 32'(set_done[6]), 1);
    chk("R6 zero len acks", 32'(acks[3]), 0);
    reg_write(13'h1068, 32'h0);
    wait_cyc(1);
    chk("R3 done cleared", 32'(set_done[6]), 0);
    preq[3] = 0;

    // R9 R10 priority under stall: ch0 and ch4
    rdy = 0;
    reg_write(13'h1000, 32'h4000);
    reg_write(13'h1004, 32'd8);
    reg_write(13'h1008, 32'h1);
    reg_write(13'h1080, 32'h5000);
    reg_write(13'h1084, 32'd8);
    reg_write(13'h1088, 32'h1);
    reg_write(13'h0C00, 32'h2);
    reg_write(13'h0C40, 32'h2);
    base_n = log_n;
    preq[0] = 1; preq[4] = 1;
    wait_cyc(6);
    chk("R10 held valid", 32'(mem_wr_valid), 1);
    chk("R9 first grant", mem_wr_addr, 32'h4000);
    chk("R10 held data", mem_wr_data, pword(0));
    chk("R10 no new grant", 32'(acks[4]), 0);
    rdy = 1;
    wait_cyc(20);
    preq[0] = 0; preq[4] = 0;
    chk("R9 count", 32'(log_n - base_n), 4);
    chk("R9 order0", log_addr[base_n], 32'h4000);
    chk("R9 order1", log_addr[base_n+1], 32'h4004);
    chk("R9 order2", log_addr[base_n+2], 32'h5000);
    chk("R9 order3", log_addr[base_n+3], 32'h5004);
    chk("R4 ch4 data", log_data[base_n+2], pword(4));

    // R11 disabled channel stays frozen (ch2)
    reg_write(13'h1050, 32'h6000);
    reg_write(13'h1054, 32'd4);
    reg_write(13'h1058, 32'h1);
    base_n = log_n;
    preq[2] = 1;
    wait_cyc(10);
    chk("R11 no write", 32'(log_n - base_n), 0);
    reg_read(13'h0C20, v); chk("R11 no switch", v, 0);
    reg_write(13'h0C20, 32'h2);
    wait_cyc(10);
    preq[2] = 0;
    chk("R7 switch after enable", 32'(log_n - base_n), 1);
    chk("R7 switch addr", log_addr[base_n], 32'h6000);
    reg_read(13'h0C20, v); chk("R7 ctrl ch2", v, 32'h3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule